// File: doc/BRIEF.md
# Up/Down Counting Register Field

This block is the storage and next-state logic of one register field that can also count. Ordinary field logic elsewhere in the register file picks a next value and a load request. This block takes that choice as its starting point and adds a counting step on top of it. An increment strobe adds a step, and a decrement strobe subtracts a step. The result is stored on the next clock edge.

Each direction is set up on its own in one of two ways. It can saturate at a limit chosen at build time. It can instead wrap modulo 2^W and pulse an overflow or underflow flag in the same cycle as the strobe. The size of each step is either a build-time constant, which defaults to 1, or a value taken from a step input port. Four flags are decoded from the stored value: two threshold flags and two saturation flags. When saturation is enabled, a final clamp pulls any next value that lies outside the limits back inside them, and it forces a load.

Top module: `ctr_field`

## Requirements
- R1: When reset is released, `value` holds RESET_VAL. The bench uses 50 for the saturating instance and 0 for the wrapping one.
- R2: The candidate is `base_next` when `base_load` is high and the stored value otherwise. With no strobe, the candidate is stored, and the stored value stays unchanged when nothing is requested.
- R3: Saturating increment stores min(candidate + step, UP_LIMIT). The sum is formed one bit wider than the field, and `overflow` stays 0 in this mode.
- R4: Saturating decrement stores DN_LIMIT when the candidate is below step + DN_LIMIT, and candidate − step otherwise. `underflow` stays 0 in this mode.
- R5: Wrapping increment stores (candidate + step) mod 2^W. In the strobe cycle, `overflow` is 1 exactly when the wide sum exceeds 2^W − 1. Without an increment, `overflow` is 0.
- R6: Wrapping decrement stores (candidate − step) mod 2^W. In the strobe cycle, `underflow` is 1 exactly when the candidate is below the step.
- R7: When both strobes are high, the increment (including any saturation) is applied first, and the decrement then works on that result.
- R8: `incr_thr_hit` = value ≥ UP_THR and `decr_thr_hit` = value ≤ DN_THR, both taken from the stored value. The defaults are 2^W − 1 and 0.
- R9: `incr_sat_hit` = value ≥ UP_LIMIT and `decr_sat_hit` = value ≤ DN_LIMIT, both taken from the stored value. The limits default to 2^W − 1 and 0.
- R10: In saturating mode, a next value above UP_LIMIT (or below DN_LIMIT) is clamped to that limit and stored, even when it comes from a plain `base_load`.
- R11: A direction with a constant step uses that constant (default 1) and ignores its step input port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_next | input | W | Next value chosen by higher-priority field logic |
| base_load | input | 1 | Request to load `base_next` |
| incr | input | 1 | Increment strobe |
| incr_step | input | STEP_W | Increment step when the port is the step source |
| decr | input | 1 | Decrement strobe |
| decr_step | input | STEP_W | Decrement step when the port is the step source |
| value | output | W | Stored field value |
| incr_thr_hit | output | 1 | Stored value at or above the upper threshold |
| decr_thr_hit | output | 1 | Stored value at or below the lower threshold |
| incr_sat_hit | output | 1 | Stored value at or above the upper limit |
| decr_sat_hit | output | 1 | Stored value at or below the lower limit |
| overflow | output | 1 | Wrapping increment passed 2^W − 1 this cycle |
| underflow | output | 1 | Wrapping decrement went below zero this cycle |

## Verification
A wrong stored value shows on `value` and on the four decoded flags one edge after the cycle that produced it. Because every later step builds on that value, the error then spreads through each following count. `overflow` and `underflow` are combinational on the candidate and the strobes, so a fault in the wide comparison is visible in the strobe cycle itself. The bench checks those flags in that cycle, and checks the stored outcome at the following clock edge.

// File: rtl/ctr_field_pkg.sv
package ctr_field_pkg;
  // Behaviour of one counting direction at its end of range
  typedef enum logic {
    CNT_WRAP = 1'b0,
    CNT_SAT  = 1'b1
  } cnt_mode_e;

  // Where the size of a counting step comes from
  typedef enum logic {
    STEP_CONST = 1'b0,
    STEP_PORT  = 1'b1
  } step_src_e;
endpackage

// File: rtl/ctr_step_sel.sv
module ctr_step_sel
  import ctr_field_pkg::*;
#(
  parameter int        W      = 8,
  parameter int        STEP_W = 4,
  parameter step_src_e SRC    = STEP_CONST,
  parameter int        FIXED  = 1
) (
  input  logic [STEP_W-1:0] step_in,
  output logic [W:0]        step_x
);
  localparam int PAD = W + 1 - STEP_W;

  generate
    if (SRC == STEP_PORT) begin : g_port
      assign step_x = {{PAD{1'b0}}, step_in};
    end else begin : g_const
      logic unused_step;
      assign unused_step = ^step_in;
      assign step_x      = (W+1)'(FIXED);
    end
  endgenerate
endmodule

// File: rtl/ctr_up_stage.sv
module ctr_up_stage
  import ctr_field_pkg::*;
#(
  parameter int        W     = 8,
  parameter cnt_mode_e MODE  = CNT_SAT,
  parameter int        LIMIT = 255
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] cand,
  input  logic [W:0]   step,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam logic [W:0]   LIM_X = (W+1)'(LIMIT);
  localparam logic [W-1:0] LIM   = W'(LIMIT);
  localparam logic [W:0]   TOP_X = {1'b0, {W{1'b1}}};

  function automatic logic [W:0] wide_add(input logic [W-1:0] a, input logic [W:0] b);
    return {1'b0, a} + b;
  endfunction

  function automatic logic [W-1:0] sat_pick(input logic [W:0] s);
    return (s > LIM_X) ? LIM : s[W-1:0];
  endfunction

  logic [W:0] sum_x;

  always_comb begin
    sum_x = wide_add(cand, step);
    res   = cand;
    ovf   = 1'b0;
    if (en) begin
      if (MODE == CNT_SAT) begin
        res = sat_pick(sum_x);
      end else begin
        res = sum_x[W-1:0];
        ovf = sum_x > TOP_X;
      end
    end
  end

  // R3: a saturating increment never leaves a result above the limit
  p_up_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && MODE == CNT_SAT) |-> (res <= LIM));
  // R5: no overflow pulse without an increment strobe
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !ovf);
endmodule

// File: rtl/ctr_dn_stage.sv
module ctr_dn_stage
  import ctr_field_pkg::*;
#(
  parameter int        W     = 8,
  parameter cnt_mode_e MODE  = CNT_SAT,
  parameter int        LIMIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] cand,
  input  logic [W:0]   step,
  output logic [W-1:0] res,
  output logic         unf
);
  localparam logic [W:0]   LIM_X = (W+1)'(LIMIT);
  localparam logic [W-1:0] LIM   = W'(LIMIT);

  function automatic logic [W:0] wide_sub(input logic [W-1:0] a, input logic [W:0] b);
    return {1'b0, a} - b;
  endfunction

  function automatic logic below_floor(input logic [W-1:0] a, input logic [W:0] b);
    return {1'b0, a} < (b + LIM_X);
  endfunction

  logic [W:0] diff_x;

  always_comb begin
    diff_x = wide_sub(cand, step);
    res    = cand;
    unf    = 1'b0;
    if (en) begin
      if (MODE == CNT_SAT) begin
        res = below_floor(cand, step) ? LIM : diff_x[W-1:0];
      end else begin
        res = diff_x[W-1:0];
        unf = {1'b0, cand} < step;
      end
    end
  end

  // R4: a saturating decrement never leaves a result below the floor
  p_dn_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && MODE == CNT_SAT) |-> (res >= LIM));
  // R6: underflow only accompanies a decrement strobe
  p_unf_needs_decr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> en);
endmodule

// File: rtl/ctr_limit_stage.sv
module ctr_limit_stage
  import ctr_field_pkg::*;
#(
  parameter int        W       = 8,
  parameter cnt_mode_e HI_MODE = CNT_SAT,
  parameter cnt_mode_e LO_MODE = CNT_SAT,
  parameter int        HI_LIM  = 255,
  parameter int        LO_LIM  = 0,
  parameter int        HI_THR  = 255,
  parameter int        LO_THR  = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pre_next,
  input  logic         pre_load,
  input  logic [W-1:0] stored,
  output logic [W-1:0] fin_next,
  output logic         fin_load,
  output logic         hi_thr,
  output logic         lo_thr,
  output logic         hi_sat,
  output logic         lo_sat
);
  localparam logic [W-1:0] HI   = W'(HI_LIM);
  localparam logic [W-1:0] LO   = W'(LO_LIM);
  localparam logic [W-1:0] HI_T = W'(HI_THR);
  localparam logic [W-1:0] LO_T = W'(LO_THR);

  logic clamp_hi, clamp_lo;

  always_comb begin
    clamp_hi = (HI_MODE == CNT_SAT) && (pre_next > HI);
    clamp_lo = (LO_MODE == CNT_SAT) && (pre_next < LO);
    fin_next = pre_next;
    if (clamp_hi) fin_next = HI;
    else if (clamp_lo) fin_next = LO;
    fin_load = pre_load | clamp_hi | clamp_lo;
  end

  assign hi_thr = stored >= HI_T;
  assign lo_thr = stored <= LO_T;
  assign hi_sat = stored >= HI;
  assign lo_sat = stored <= LO;

  // R10: an out-of-range next value under saturation is pulled in and loaded
  p_lo_clamp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (LO_MODE == CNT_SAT && pre_next < LO) |-> (fin_load && fin_next == LO));
  p_hi_clamp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (HI_MODE == CNT_SAT && pre_next > HI) |-> (fin_load && fin_next == HI));
endmodule

// File: rtl/ctr_field.sv
module ctr_field
  import ctr_field_pkg::*;
#(
  parameter int        W           = 8,
  parameter int        STEP_W      = 4,
  parameter cnt_mode_e UP_MODE     = CNT_SAT,
  parameter cnt_mode_e DN_MODE     = CNT_SAT,
  parameter step_src_e UP_STEP_SRC = STEP_CONST,
  parameter step_src_e DN_STEP_SRC = STEP_CONST,
  parameter int        UP_STEP     = 1,
  parameter int        DN_STEP     = 1,
  parameter int        UP_LIMIT    = (1 << W) - 1,
  parameter int        DN_LIMIT    = 0,
  parameter int        UP_THR      = (1 << W) - 1,
  parameter int        DN_THR      = 0,
  parameter int        RESET_VAL   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      base_next,
  input  logic              base_load,
  input  logic              incr,
  input  logic [STEP_W-1:0] incr_step,
  input  logic              decr,
  input  logic [STEP_W-1:0] decr_step,
  output logic [W-1:0]      value,
  output logic              incr_thr_hit,
  output logic              decr_thr_hit,
  output logic              incr_sat_hit,
  output logic              decr_sat_hit,
  output logic              overflow,
  output logic              underflow
);
  localparam logic [W-1:0] RST_V = W'(RESET_VAL);
  localparam logic [W-1:0] HI_V  = W'(UP_LIMIT);
  localparam logic [W-1:0] LO_V  = W'(DN_LIMIT);

  logic [W-1:0] q;
  logic [W-1:0] cand, up_res, dn_res, fin_next;
  logic [W:0]   up_step_x, dn_step_x;
  logic         fin_load;

  assign cand = base_load ? base_next : q;

  ctr_step_sel #(.W(W), .STEP_W(STEP_W), .SRC(UP_STEP_SRC), .FIXED(UP_STEP)) u_up_step (
    .step_in(incr_step), .step_x(up_step_x));

  ctr_step_sel #(.W(W), .STEP_W(STEP_W), .SRC(DN_STEP_SRC), .FIXED(DN_STEP)) u_dn_step (
    .step_in(decr_step), .step_x(dn_step_x));

  ctr_up_stage #(.W(W), .MODE(UP_MODE), .LIMIT(UP_LIMIT)) u_up (
    .clk(clk), .rst_n(rst_n), .en(incr), .cand(cand), .step(up_step_x),
    .res(up_res), .ovf(overflow));

  // Decrement works on the increment result (R7)
  ctr_dn_stage #(.W(W), .MODE(DN_MODE), .LIMIT(DN_LIMIT)) u_dn (
    .clk(clk), .rst_n(rst_n), .en(decr), .cand(up_res), .step(dn_step_x),
    .res(dn_res), .unf(underflow));

  ctr_limit_stage #(
    .W(W), .HI_MODE(UP_MODE), .LO_MODE(DN_MODE),
    .HI_LIM(UP_LIMIT), .LO_LIM(DN_LIMIT), .HI_THR(UP_THR), .LO_THR(DN_THR)
  ) u_lim (
    .clk(clk), .rst_n(rst_n),
    .pre_next(dn_res), .pre_load(base_load | incr | decr), .stored(q),
    .fin_next(fin_next), .fin_load(fin_load),
    .hi_thr(incr_thr_hit), .lo_thr(decr_thr_hit),
    .hi_sat(incr_sat_hit), .lo_sat(decr_sat_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= RST_V;
    else if (fin_load) q <= fin_next;
  end

  assign value = q;

  // R2: with no request the stored value holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_load && !incr && !decr) |=> $stable(value));

  generate
    if (UP_MODE == CNT_SAT) begin : g_hi_chk
      // R9: under saturation the stored value stays at or below the ceiling
      p_ceiling_r9: assert property (@(posedge clk) disable iff (!rst_n)
        incr |=> (value <= HI_V));
    end
    if (DN_MODE == CNT_SAT) begin : g_lo_chk
      p_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        decr |=> (value >= LO_V));
    end
  endgenerate
endmodule

// File: tb/ctr_field_tb.sv
module ctr_field_tb;
  import ctr_field_pkg::*;

  localparam int TCLK = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] base_next = '0;
  logic       base_load = 1'b0, incr = 1'b0, decr = 1'b0;
  logic [3:0] incr_step = '0, decr_step = '0;

  logic [7:0] s_val, w_val;
  logic s_ith, s_dth, s_isat, s_dsat, s_ovf, s_unf;
  logic w_ith, w_dth, w_isat, w_dsat, w_ovf, w_unf;

  int checks = 0, errors = 0;
  int ms, mw;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  // Saturating instance: limits 10..200, thresholds 40/150, step ports
  ctr_field #(
    .W(8), .STEP_W(4), .UP_MODE(CNT_SAT), .DN_MODE(CNT_SAT),
    .UP_STEP_SRC(STEP_PORT), .DN_STEP_SRC(STEP_PORT),
    .UP_LIMIT(200), .DN_LIMIT(10), .UP_THR(150), .DN_THR(40), .RESET_VAL(50)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .base_next(base_next), .base_load(base_load),
    .incr(incr), .incr_step(incr_step), .decr(decr), .decr_step(decr_step),
    .value(s_val), .incr_thr_hit(s_ith), .decr_thr_hit(s_dth),
    .incr_sat_hit(s_isat), .decr_sat_hit(s_dsat), .overflow(s_ovf), .underflow(s_unf));

  // Wrapping instance: port step up, constant step 1 down, thresholds 5/128
  ctr_field #(
    .W(8), .STEP_W(4), .UP_MODE(CNT_WRAP), .DN_MODE(CNT_WRAP),
    .UP_STEP_SRC(STEP_PORT), .DN_STEP_SRC(STEP_CONST),
    .UP_THR(128), .DN_THR(5), .RESET_VAL(0)
  ) u_dut_wrap (
    .clk(clk), .rst_n(rst_n), .base_next(base_next), .base_load(base_load),
    .incr(incr), .incr_step(incr_step), .decr(decr), .decr_step(decr_step),
    .value(w_val), .incr_thr_hit(w_ith), .decr_thr_hit(w_dth),
    .incr_sat_hit(w_isat), .decr_sat_hit(w_dsat), .overflow(w_ovf), .underflow(w_unf));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat_model(input int c, input bit i, input int is, input bit d, input int ds);
    int v = c;
    if (i) v = (v + is > 200) ? 200 : v + is;
    if (d) v = (v < ds + 10) ? 10 : v - ds;
    if (v > 200) v = 200;
    if (v < 10) v = 10;
    return v;
  endfunction

  function automatic int wrap_model(input int c, input bit i, input int is, input bit d,
                                    output bit ov, output bit un);
    int v = c;
    ov = 0; un = 0;
    if (i) begin ov = (v + is) > 255; v = (v + is) % 256; end
    if (d) begin un = (v < 1); v = (v + 255) % 256; end
    return v;
  endfunction

  task automatic step(input string tag, input bit ld, input int nv, input bit i,
                      input int is, input bit d, input int ds);
    int cs, cw, ns, nw;
    bit eo, eu;
    @(negedge clk);
    base_load = ld; base_next = 8'(nv);
    incr = i; incr_step = 4'(is); decr = d; decr_step = 4'(ds);
    #1;
    check(s_val == 8'(ms), {tag, " sat value"}, s_val, ms);
    check(w_val == 8'(mw), {tag, " wrap value"}, w_val, mw);
    check(s_ith == (ms >= 150) && s_dth == (ms <= 40), "R8 sat thresholds",
          {s_ith, s_dth}, {ms >= 150, ms <= 40});
    check(w_ith == (mw >= 128) && w_dth == (mw <= 5), "R8 wrap thresholds",
          {w_ith, w_dth}, {mw >= 128, mw <= 5});
    check(s_isat == (ms >= 200) && s_dsat == (ms <= 10), "R9 sat limit flags",
          {s_isat, s_dsat}, {ms >= 200, ms <= 10});
    check(w_isat == (mw >= 255) && w_dsat == (mw <= 0), "R9 wrap limit flags",
          {w_isat, w_dsat}, {mw >= 255, mw <= 0});
    cs = ld ? nv : ms;
    cw = ld ? nv : mw;
    ns = sat_model(cs, i, is, d, ds);
    nw = wrap_model(cw, i, is, d, eo, eu);
    check(!s_ovf && !s_unf, "R3/R4 sat no wrap flags", {s_ovf, s_unf}, 0);
    check(w_ovf == eo, "R5 overflow", w_ovf, eo);
    check(w_unf == eu, "R6 underflow", w_unf, eu);
    @(posedge clk);
    ms = ns;
    mw = nw;
  endtask

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    ms = 50; mw = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check(s_val == 8'd50, "R1 reset sat", s_val, 50);
    check(w_val == 8'd0, "R1 reset wrap", w_val, 0);

    step("R2 hold", 0, 0, 0, 0, 0, 0);
    step("R2 load", 1, 120, 0, 0, 0, 0);
    step("R2 hold after load", 0, 0, 0, 0, 0, 0);
    step("R3 near ceiling", 1, 195, 1, 9, 0, 0);
    step("R3 at ceiling", 0, 0, 1, 3, 0, 0);
    step("R10 load above ceiling", 1, 250, 0, 0, 0, 0);
    step("R10 load below floor", 1, 5, 0, 0, 0, 0);
    step("R4 floor", 1, 15, 0, 0, 1, 7);
    step("R4 normal", 1, 30, 0, 0, 1, 7);
    step("R5 wrap past top", 1, 250, 1, 9, 0, 0);
    step("R5 exact top", 1, 246, 1, 9, 0, 0);
    step("R6 wrap below zero", 1, 0, 0, 0, 1, 9);
    step("R11 const step ignores port", 1, 100, 0, 0, 1, 15);
    step("R7 both strobes", 1, 198, 1, 8, 1, 5);
    step("R7 both strobes wrap", 1, 255, 1, 1, 1, 3);
    step("R7 check", 0, 0, 0, 0, 0, 0);

    for (int k = 0; k < 3000; k++) begin
      step("R2/R3/R4/R5/R6/R7/R10 random",
           ($urandom % 5) == 0, $urandom % 256,
           $urandom % 2, $urandom % 16, $urandom % 2, $urandom % 16);
    end
    step("random final", 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule